// File: doc/BRIEF.md
# Serial Configuration Frame Integrity Checker

This block watches a configuration bitstream that arrives one bit per clock, qualified by a valid strobe. It locates each frame by its start pair and follows the frame's fixed layout. On every frame it runs up to three integrity tests: a device identity comparison, a stop-bit alignment test and a byte checksum. Each frame that passes raises a single-cycle done pulse. Writing payload into configuration storage is handled elsewhere.

The first error that is detected is recorded as a two-bit code. The checker then parks in a locked state and pulls its active-low ready output low. It ignores all further stream bits until the asynchronous reset is applied or a one-cycle program request arrives. Either of these clears the error and restarts the search for a frame start.

Top module: `cfgchk_top`

## Requirements
- R1: A stream bit is consumed only in a cycle where `cfg_vld` is high. Cycles with `cfg_vld` low change no state and produce no event.
- R2: A frame is the bit pair 0 then 1, then one header flag bit (1 marks an identity frame), then PAYLOAD_W payload bits sent most significant bit first, then an 8-bit checksum byte sent MSB first, then 8 stop bits. Between frames the line carries any number of 1 bits.
- R3: In an identity frame, the first ID_W payload bits are compared with DEVICE_ID. On a mismatch, `err_code` becomes 01 in the cycle after the last of those bits is consumed.
- R4: If any of the 8 stop bits of a frame is 0, `err_code` becomes 10 in the cycle after the 1 bit that completes the next start pair.
- R5: The checksum is the modulo-256 sum of the payload bytes. If it differs from the received checksum byte, `err_code` becomes 11 in the cycle after the last checksum bit.
- R6: `frame_ok` is high for exactly one cycle, in the cycle after the last checksum bit, when the frame raised no error.
- R7: While `err_code` is not 00, `init_n` is low. The block keeps the first error code and ignores all stream bits: it emits no `frame_ok` and no code change. While `err_code` is 00, `init_n` is high.
- R8: A one-cycle `prog` pulse clears `err_code` to 00, drives `init_n` high, forgets any stop-bit fault and restarts the search for a frame start.
- R9: While `rst_n` is low, `init_n` is high, `err_code` is 00 and `frame_ok` is low. The release of reset is synchronized internally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog | input | 1 | Synchronous restart request, one cycle |
| cfg_bit | input | 1 | Serial stream bit |
| cfg_vld | input | 1 | Qualifies `cfg_bit` |
| init_n | output | 1 | Low while an error is latched |
| err_code | output | 2 | 00 none, 01 identity, 10 alignment, 11 checksum |
| frame_ok | output | 1 | One-cycle pulse per clean frame |

## Verification
The bench builds the block with PAYLOAD_W = 32, ID_W = 16 and DEVICE_ID = 16'hA5C3. A whole frame then takes 51 stream bits, so dozens of frames fit in a short run, including frames with valid-low gaps. Because ID_W is half the payload, an identity frame carries payload bits after its identity field that are still summed. This lets the bench exercise the case where an identity mismatch and a bad checksum occur in the same frame, and show that the earlier identity error wins.

// File: rtl/cfgchk_pkg.sv
package cfgchk_pkg;
  typedef enum logic [1:0] {
    ERR_NONE  = 2'b00,
    ERR_ID    = 2'b01,
    ERR_ALIGN = 2'b10,
    ERR_SUM   = 2'b11
  } err_e;

  typedef enum logic [2:0] {
    ST_HUNT,
    ST_HDR,
    ST_PAY,
    ST_CHK,
    ST_STOP,
    ST_LOCK
  } st_e;
endpackage

// File: rtl/cfgchk_byte_sum.sv
module cfgchk_byte_sum (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       en,
  input  logic       bit_i,
  output logic [7:0] sum_o
);
  logic [6:0] sh_q, sh_d;
  logic [2:0] bc_q, bc_d;
  logic [7:0] sum_q, sum_d;

  always_comb begin
    sh_d  = sh_q;
    bc_d  = bc_q;
    sum_d = sum_q;
    if (clr) begin
      sh_d  = '0;
      bc_d  = '0;
      sum_d = '0;
    end else if (en) begin
      sh_d = {sh_q[5:0], bit_i};
      bc_d = bc_q + 3'd1;
      if (bc_q == 3'd7) sum_d = sum_q + {sh_q, bit_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      bc_q  <= '0;
      sum_q <= '0;
    end else if (clr || en) begin
      sh_q  <= sh_d;
      bc_q  <= bc_d;
      sum_q <= sum_d;
    end
  end

  assign sum_o = sum_q;
endmodule

// File: rtl/cfgchk_id_match.sv
module cfgchk_id_match #(
  parameter int unsigned      ID_W      = 32,
  parameter logic [ID_W-1:0]  DEVICE_ID = '0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  input  logic bit_i,
  output logic hit_o
);
  logic [ID_W-2:0] sh_q, sh_d;

  always_comb begin
    sh_d = sh_q;
    if (clr)     sh_d = '0;
    else if (en) sh_d = {sh_q[ID_W-3:0], bit_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         sh_q <= '0;
    else if (clr || en) sh_q <= sh_d;
  end

  // compare includes the bit being consumed this cycle
  assign hit_o = ({sh_q, bit_i} == DEVICE_ID);
endmodule

// File: rtl/cfgchk_top.sv
module cfgchk_top
  import cfgchk_pkg::*;
#(
  parameter int unsigned     PAYLOAD_W = 64,
  parameter int unsigned     ID_W      = 32,
  parameter logic [ID_W-1:0] DEVICE_ID = 32'h4D3C_2B1A
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       prog,
  input  logic       cfg_bit,
  input  logic       cfg_vld,
  output logic       init_n,
  output logic [1:0] err_code,
  output logic       frame_ok
);
  localparam int unsigned CW = $clog2(PAYLOAD_W);
  localparam logic [CW-1:0] PAY_LAST = CW'(PAYLOAD_W - 1);
  localparam logic [CW-1:0] ID_LAST  = CW'(ID_W - 1);
  localparam logic [CW-1:0] BYTE_LAST = CW'(7);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rsync_q;
  logic       rst_q_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_q_n = rsync_q[1];

  st_e          st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          last_q, last_d;
  logic          sbad_q, sbad_d;
  logic          isid_q, isid_d;
  logic [6:0]    chk_q, chk_d;
  err_e          err_q, err_d;
  logic          ok_q, ok_d;

  logic       take, start_hit, sum_en, id_en, id_hit;
  logic [7:0] sum;

  assign take      = cfg_vld && (st_q != ST_LOCK);
  assign start_hit = take && (st_q == ST_HUNT) && !last_q && cfg_bit;
  assign sum_en    = take && (st_q == ST_PAY);
  assign id_en     = sum_en && isid_q && (cnt_q <= ID_LAST);

  cfgchk_byte_sum u_sum (
    .clk(clk), .rst_n(rst_q_n), .clr(start_hit), .en(sum_en),
    .bit_i(cfg_bit), .sum_o(sum)
  );

  cfgchk_id_match #(.ID_W(ID_W), .DEVICE_ID(DEVICE_ID)) u_id (
    .clk(clk), .rst_n(rst_q_n), .clr(start_hit), .en(id_en),
    .bit_i(cfg_bit), .hit_o(id_hit)
  );

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    last_d = last_q;
    sbad_d = sbad_q;
    isid_d = isid_q;
    chk_d  = chk_q;
    err_d  = err_q;
    ok_d   = 1'b0;
    if (prog) begin
      st_d   = ST_HUNT;
      last_d = 1'b1;
      sbad_d = 1'b0;
      err_d  = ERR_NONE;
    end else if (take) begin
      last_d = cfg_bit;
      unique case (st_q)
        ST_HUNT: if (start_hit) begin
          if (sbad_q) begin
            st_d  = ST_LOCK;
            err_d = ERR_ALIGN;
          end else begin
            st_d   = ST_HDR;
            sbad_d = 1'b0;
          end
        end
        ST_HDR: begin
          isid_d = cfg_bit;
          cnt_d  = '0;
          st_d   = ST_PAY;
        end
        ST_PAY: begin
          cnt_d = cnt_q + CW'(1);
          if (isid_q && (cnt_q == ID_LAST) && !id_hit) begin
            st_d  = ST_LOCK;
            err_d = ERR_ID;
          end else if (cnt_q == PAY_LAST) begin
            st_d  = ST_CHK;
            cnt_d = '0;
          end
        end
        ST_CHK: begin
          chk_d = {chk_q[5:0], cfg_bit};
          cnt_d = cnt_q + CW'(1);
          if (cnt_q == BYTE_LAST) begin
            if ({chk_q, cfg_bit} != sum) begin
              st_d  = ST_LOCK;
              err_d = ERR_SUM;
            end else begin
              ok_d  = 1'b1;
              st_d  = ST_STOP;
              cnt_d = '0;
            end
          end
        end
        ST_STOP: begin
          cnt_d = cnt_q + CW'(1);
          if (!cfg_bit) sbad_d = 1'b1;
          if (cnt_q == BYTE_LAST) st_d = ST_HUNT;
        end
        default: st_d = ST_LOCK;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      st_q   <= ST_HUNT;
      cnt_q  <= '0;
      last_q <= 1'b1;
      sbad_q <= 1'b0;
      isid_q <= 1'b0;
      chk_q  <= '0;
      err_q  <= ERR_NONE;
      ok_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      last_q <= last_d;
      sbad_q <= sbad_d;
      isid_q <= isid_d;
      chk_q  <= chk_d;
      err_q  <= err_d;
      ok_q   <= ok_d;
    end
  end

  assign init_n   = (st_q != ST_LOCK);
  assign err_code = err_q;
  assign frame_ok = ok_q;
endmodule

module cfgchk_sva (
  input logic       clk,
  input logic       rst_n,
  input logic       prog,
  input logic       cfg_vld,
  input logic       init_n,
  input logic [1:0] err_code,
  input logic       frame_ok
);
  a_r7_low_when_err: assert property (@(posedge clk) disable iff (!rst_n)
    (err_code != 2'b00) |-> !init_n);
  a_r7_high_when_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (err_code == 2'b00) |-> init_n);
  a_r7_code_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err_code != 2'b00 && !prog) |=> $stable(err_code));
  a_r8_prog_clears: assert property (@(posedge clk) disable iff (!rst_n)
    prog |=> (err_code == 2'b00 && init_n));
  a_r1_no_event_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_vld && !prog) |=> ($stable(err_code) && !frame_ok));
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ok |=> !frame_ok);
  a_r6_pulse_clean: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ok |-> (init_n && err_code == 2'b00));
endmodule

bind cfgchk_top cfgchk_sva u_sva (.*);

// File: tb/tb_cfgchk_top.sv
module tb_cfgchk_top;
  localparam int CLK_P = 10;
  localparam int PW = 32;
  localparam int IW = 16;
  localparam logic [IW-1:0] DID = 16'hA5C3;

  logic clk, rst_n, prog, cfg_bit, cfg_vld;
  logic init_n, frame_ok;
  logic [1:0] err_code;

  int total, bad;
  int expq[$];
  bit m_lock, m_sbad;

  cfgchk_top #(.PAYLOAD_W(PW), .ID_W(IW), .DEVICE_ID(DID)) dut (
    .clk(clk), .rst_n(rst_n), .prog(prog), .cfg_bit(cfg_bit),
    .cfg_vld(cfg_vld), .init_n(init_n), .err_code(err_code),
    .frame_ok(frame_ok)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: pop one expected item per observed event
  logic prev_init;
  initial begin
    prev_init = 1'b1;
    forever begin
      @(negedge clk);
      if (rst_n && frame_ok) begin
        if (expq.size() == 0) chk("R7 unexpected frame_ok", 1, 0);
        else chk("R6 frame_ok outcome", 0, expq.pop_front());
      end
      if (rst_n && prev_init && !init_n) begin
        if (expq.size() == 0) chk("R7 unexpected error", int'(err_code), 0);
        else chk("R3/R4/R5 error code", int'(err_code), expq.pop_front());
      end
      prev_init = init_n;
    end
  end

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic send_bit(input bit b, input bit gap);
    if (gap) begin
      @(posedge clk); #1;
      cfg_vld = 1'b0;
      cfg_bit = ~b;  // R1: must be ignored
    end
    @(posedge clk); #1;
    cfg_vld = 1'b1;
    cfg_bit = b;
    @(posedge clk); #1;
    cfg_vld = 1'b0;
  endtask

  task automatic send_frame(input bit hdr, input logic [PW-1:0] pay,
                            input bit bad_sum, input bit bad_stop, input bit gap);
    logic [7:0] s;
    s = pay[31:24] + pay[23:16] + pay[15:8] + pay[7:0];
    if (bad_sum) s = s ^ 8'h10;
    if (!m_lock) begin
      if (m_sbad) begin expq.push_back(2); m_lock = 1; end
      else if (hdr && pay[PW-1 -: IW] != DID) begin expq.push_back(1); m_lock = 1; end
      else if (bad_sum) begin expq.push_back(3); m_lock = 1; end
      else begin expq.push_back(0); m_sbad = bad_stop; end
    end
    send_bit(1, 0); send_bit(1, gap);
    send_bit(0, gap); send_bit(1, gap);
    send_bit(hdr, gap);
    for (int i = PW - 1; i >= 0; i--) send_bit(pay[i], gap && (i % 5 == 0));
    for (int i = 7; i >= 0; i--) send_bit(s[i], gap);
    for (int i = 0; i < 8; i++) send_bit(!(bad_stop && i == 3), gap);
    repeat (3) @(posedge clk);
  endtask

  task automatic pulse_prog();
    @(posedge clk); #1 prog = 1'b1;
    @(posedge clk); #1 prog = 1'b0;
    m_lock = 0; m_sbad = 0;
    @(negedge clk);
    chk("R8 init_n after prog", int'(init_n), 1);
    chk("R8 err_code after prog", int'(err_code), 0);
  endtask

  initial begin
    total = 0; bad = 0; m_lock = 0; m_sbad = 0;
    rst_n = 1'b0; prog = 1'b0; cfg_bit = 1'b1; cfg_vld = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 init_n in reset", int'(init_n), 1);
    chk("R9 err_code in reset", int'(err_code), 0);
    chk("R9 frame_ok in reset", int'(frame_ok), 0);
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R2 R6: clean data and identity frames, with and without gaps (R1)
    send_frame(0, 32'h1234_5678, 0, 0, 0);
    send_frame(1, {DID, 16'h00FF}, 0, 0, 1);
    send_frame(0, 32'hFFFF_FFFF, 0, 0, 1);
    // R5: checksum fault
    send_frame(0, 32'hDEAD_BEEF, 1, 0, 0);
    chk("R7 init_n low after error", int'(init_n), 0);
    // R7: locked, clean frame ignored, code kept
    send_frame(0, 32'h0102_0304, 0, 0, 0);
    @(negedge clk);
    chk("R7 code kept while locked", int'(err_code), 3);
    pulse_prog();
    // R3: identity mismatch
    send_frame(1, 32'h1111_2222, 0, 0, 1);
    chk("R3 code", int'(err_code), 1);
    pulse_prog();
    // R4: bad stop bit, then next frame start
    send_frame(0, 32'hCAFE_0001, 0, 1, 0);
    send_frame(0, 32'h0000_0000, 0, 0, 0);
    chk("R4 code", int'(err_code), 2);
    pulse_prog();
    // R8: prog forgets stop fault
    send_frame(0, 32'h8080_8080, 0, 1, 0);
    pulse_prog();
    send_frame(0, 32'h7F7F_7F7F, 0, 0, 0);
    chk("R8 no alignment after prog", int'(err_code), 0);
    // R7: identity mismatch and bad checksum, first kept
    send_frame(1, 32'h0000_9999, 1, 0, 0);
    chk("R7 first error kept", int'(err_code), 1);
    // R9: asynchronous reset mid-run
    #3 rst_n = 1'b0;
    #1;
    chk("R9 init_n async reset", int'(init_n), 1);
    chk("R9 err_code async reset", int'(err_code), 0);
    m_lock = 0; m_sbad = 0;
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    for (int k = 0; k < 6; k++)
      send_frame(k % 2, (k % 2) ? {DID, 16'(k * 4099)} : 32'(k * 32'h1357_9BDF), 0, 0, k > 2);
    repeat (5) @(negedge clk);
    chk("R6 all expected events seen", expq.size(), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule